// File: doc/BRIEF.md
# Translation Lookaside Buffer with Lockdown Partition

This block holds virtual-to-physical page translations for a processor core. Instruction fetches and data accesses share the one lookup port. A miss is reported to the surrounding logic, which runs the page walk and returns the translation on the fill port. The block only stores, matches, replaces and invalidates translations. Page walking, permission checking and fault reporting are done elsewhere.

Storage has two regions. An eight-slot fully-associative region keeps translations that software has pinned. Software picks the slot, and the hardware never evicts from this region. A 2-way, 16-set cache holds all other translations and replaces them round-robin within each set. The lockdown flag sent with a fill chooses the region. Entries already stored never move between regions. When both regions match, the pinned translation is returned. The enable input only masks lookups, so stored entries stay in place while translation is switched off.

Top module: `xlat_tlb`

## Requirements
- R1: After reset, no entry in either region is valid, and every lookup returns `lk_hit` = 0.
- R2: A fill with `fill_lock` = 0 stores the translation in set `fill_vpn[3:0]` of the set region. The next cycle, a lookup of that VPN returns `lk_hit` = 1 with the stored `lk_ppn` and `lk_perm`. The one port serves both fetch and data lookups.
- R3: Each set has a replacement pointer that starts at way 0 after reset. It advances by one (modulo 2) on every non-locked fill to that set. A fill of a new VPN goes into the way the pointer selects. So the third distinct VPN filled into a set evicts the first, and other sets are not affected.
- R4: A non-locked fill of a VPN that is already valid in its set overwrites that way and does not create a second copy. The set's pointer still advances.
- R5: A fill with `fill_lock` = 1 writes lockdown slot `fill_slot` (0 to 7) and sets its valid bit. The set region is not written. Filling a slot that is already occupied replaces its previous translation.
- R6: When both regions hold a valid entry for the looked-up VPN, `lk_ppn` and `lk_perm` come from the lockdown entry.
- R7: `inv_all` clears every set-region entry in one cycle. All lockdown entries keep their valid state and contents.
- R8: `inv_addr_valid` with `inv_addr_vpn` clears, in one cycle, every valid entry in either region whose VPN equals it. All other entries are unaffected.
- R9: While `enable` = 0, `lk_hit` is 0. Dropping `enable` and raising it again leaves every stored entry intact and hitting.
- R10: A fill and an invalidate in the same cycle both take effect, and the fill is applied last. The filled entry is valid afterwards.
- R11: Non-locked fills never evict a lockdown entry, even when they map to the same set index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Translation enable; masks lookup hits when low |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 20 | Physical page number of the hit (0 on a miss) |
| lk_perm | output | 4 | Permission bits of the hit (0 on a miss) |
| fill_valid | input | 1 | Write a translation this cycle |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_ppn | input | 20 | Fill physical page number |
| fill_perm | input | 4 | Fill permission bits |
| fill_lock | input | 1 | 1 = write a lockdown slot, 0 = write the set region |
| fill_slot | input | 3 | Lockdown slot index used when `fill_lock` = 1 |
| inv_all | input | 1 | Clear the whole set region |
| inv_addr_valid | input | 1 | Invalidate entries matching `inv_addr_vpn` |
| inv_addr_vpn | input | 20 | VPN to invalidate |

## Verification
The invalidate checks assume that no fill arrives in the same cycle, so those properties are qualified with a quiet fill port. The bench keeps every invalidate clear of fills except in the one scenario that targets R10. The single-hit-per-set property depends on the refill-in-place rule. The stimulus refills a resident VPN on purpose so that this path is exercised. Duplicate VPNs across lockdown slots are allowed, and the bench never creates them.

// File: rtl/tlb_pkg.sv
// Package: default geometry for the translation buffer.
// Assumes: the set count and way count are powers of two.
package tlb_pkg;
    localparam int unsigned VPN_BITS   = 20;
    localparam int unsigned PPN_BITS   = 20;
    localparam int unsigned PERM_BITS  = 4;
    localparam int unsigned LOCK_SLOTS = 8;
    localparam int unsigned NUM_SETS   = 16;
    localparam int unsigned NUM_WAYS   = 2;
endpackage

// File: rtl/tlb_lock_region.sv
// Fully-associative pinned-translation store.
// A write goes to the slot that software names. Entries leave only when that
// slot is rewritten or when an address invalidate matches them.
// Assumes: a write and a matching invalidate in the same cycle leave the slot
// valid, because the write is applied last.
module tlb_lock_region #(
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned PPN_W  = 20,
    parameter int unsigned PERM_W = 4,
    parameter int unsigned SLOTS  = 8,
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              hit,
    output logic [PPN_W-1:0]  hit_ppn,
    output logic [PERM_W-1:0] hit_perm,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn,
    output logic [SLOTS-1:0]  valid_o
);
    logic [SLOTS-1:0]  vld;
    logic [VPN_W-1:0]  vpn_q  [SLOTS];
    logic [PPN_W-1:0]  ppn_q  [SLOTS];
    logic [PERM_W-1:0] perm_q [SLOTS];

    assign valid_o = vld;

    // Per-slot valid state: address invalidate first, then the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (inv_en && vld[i] && (vpn_q[i] == inv_vpn))
                    vld[i] <= 1'b0;
                if (wr_en && (SLOT_W'(i) == wr_slot))
                    vld[i] <= 1'b1;
            end
        end
    end

    // Slot payload; this storage is not reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < SLOTS; i++) begin
            if (wr_en && (SLOT_W'(i) == wr_slot)) begin
                vpn_q[i]  <= wr_vpn;
                ppn_q[i]  <= wr_ppn;
                perm_q[i] <= wr_perm;
            end
        end
    end

    // Compare all slots; the lowest-numbered matching slot wins.
    always_comb begin
        hit      = 1'b0;
        hit_ppn  = '0;
        hit_perm = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (vld[i] && (vpn_q[i] == lk_vpn)) begin
                hit      = 1'b1;
                hit_ppn  = ppn_q[i];
                hit_perm = perm_q[i];
            end
        end
    end

    // R5: a pinned write leaves its slot valid on the next cycle
    a_r5_slot_valid_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld[$past(wr_slot)]);
endmodule

// File: rtl/tlb_set_region.sv
// Set-associative cache of ordinary translations.
// The set index is taken from the low VPN bits, and the full VPN is kept as the tag.
// A fill to a VPN that is already resident overwrites that way. Otherwise the
// fill goes into the way chosen by the set's round-robin pointer. The pointer
// advances on every fill to its set.
// Assumes: SETS and WAYS are powers of two.
module tlb_set_region #(
    parameter int unsigned VPN_W  = 20,
    parameter int unsigned PPN_W  = 20,
    parameter int unsigned PERM_W = 4,
    parameter int unsigned SETS   = 16,
    parameter int unsigned WAYS   = 2,
    localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int unsigned PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int unsigned ENTRIES = SETS * WAYS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              hit,
    output logic [PPN_W-1:0]  hit_ppn,
    output logic [PERM_W-1:0] hit_perm,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              clr_all,
    input  logic              inv_en,
    input  logic [VPN_W-1:0]  inv_vpn
);
    logic [ENTRIES-1:0] vld;
    logic [VPN_W-1:0]   vpn_q  [SETS][WAYS];
    logic [PPN_W-1:0]   ppn_q  [SETS][WAYS];
    logic [PERM_W-1:0]  perm_q [SETS][WAYS];
    logic [PTR_W-1:0]   rr_ptr [SETS];

    logic [IDX_W-1:0]   lk_set, wr_set, inv_set;
    logic [WAYS-1:0]    way_hit;
    logic               wr_found;
    logic [PTR_W-1:0]   wr_match_way;
    logic [PTR_W-1:0]   wr_way;

    assign lk_set  = lk_vpn[IDX_W-1:0];
    assign wr_set  = wr_vpn[IDX_W-1:0];
    assign inv_set = inv_vpn[IDX_W-1:0];

    // Look up every way of the indexed set and select the matching one.
    always_comb begin
        hit      = 1'b0;
        hit_ppn  = '0;
        hit_perm = '0;
        way_hit  = '0;
        for (int w = 0; w < WAYS; w++) begin
            way_hit[w] = vld[int'(lk_set) * WAYS + w] && (vpn_q[lk_set][w] == lk_vpn);
            if (way_hit[w]) begin
                hit      = 1'b1;
                hit_ppn  = ppn_q[lk_set][w];
                hit_perm = perm_q[lk_set][w];
            end
        end
    end

    // Pick the fill way: the resident copy if there is one, else the pointer's way.
    always_comb begin
        wr_found     = 1'b0;
        wr_match_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (vld[int'(wr_set) * WAYS + w] && (vpn_q[wr_set][w] == wr_vpn)) begin
                wr_found     = 1'b1;
                wr_match_way = PTR_W'(w);
            end
        end
        wr_way = wr_found ? wr_match_way : rr_ptr[wr_set];
    end

    // Valid bits: clear-all and address invalidate first, then the fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (clr_all)
                vld <= '0;
            if (inv_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (vpn_q[inv_set][w] == inv_vpn)
                        vld[int'(inv_set) * WAYS + w] <= 1'b0;
                end
            end
            if (wr_en)
                vld[int'(wr_set) * WAYS + int'(wr_way)] <= 1'b1;
        end
    end

    // Replacement pointers: each one steps forward on a fill to its set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                rr_ptr[s] <= '0;
        end else if (wr_en) begin
            rr_ptr[wr_set] <= (int'(rr_ptr[wr_set]) == WAYS - 1) ? '0 : rr_ptr[wr_set] + 1'b1;
        end
    end

    // Entry payload; this storage is not reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            vpn_q[wr_set][wr_way]  <= wr_vpn;
            ppn_q[wr_set][wr_way]  <= wr_ppn;
            perm_q[wr_set][wr_way] <= wr_perm;
        end
    end

    // R4: refill in place keeps at most one matching way per set
    a_r4_single_way_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R7: a clear-all with no fill leaves the region empty
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && !wr_en) |=> ($countones(vld) == 0));
endmodule

// File: rtl/xlat_tlb.sv
// Unified translation buffer: one lookup port serves both fetch and data.
// It combines the pinned region and the set region, gives the pinned region
// priority on a double match, and masks hits while translation is disabled.
// Fills are accepted whatever the state of enable.
// Assumes: the caller sends one fill per miss; no backpressure exists.
module xlat_tlb
    import tlb_pkg::*;
#(
    parameter int unsigned VPN_W  = VPN_BITS,
    parameter int unsigned PPN_W  = PPN_BITS,
    parameter int unsigned PERM_W = PERM_BITS,
    parameter int unsigned SLOTS  = LOCK_SLOTS,
    parameter int unsigned SETS   = NUM_SETS,
    parameter int unsigned WAYS   = NUM_WAYS,
    localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_perm,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              fill_lock,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic              inv_all,
    input  logic              inv_addr_valid,
    input  logic [VPN_W-1:0]  inv_addr_vpn
);
    logic              pin_hit, set_hit;
    logic [PPN_W-1:0]  pin_ppn, set_ppn;
    logic [PERM_W-1:0] pin_perm, set_perm;
    logic [SLOTS-1:0]  pin_valid;

    tlb_lock_region #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W), .SLOTS(SLOTS)
    ) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (lk_vpn),
        .hit      (pin_hit),
        .hit_ppn  (pin_ppn),
        .hit_perm (pin_perm),
        .wr_en    (fill_valid && fill_lock),
        .wr_slot  (fill_slot),
        .wr_vpn   (fill_vpn),
        .wr_ppn   (fill_ppn),
        .wr_perm  (fill_perm),
        .inv_en   (inv_addr_valid),
        .inv_vpn  (inv_addr_vpn),
        .valid_o  (pin_valid)
    );

    tlb_set_region #(
        .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W), .SETS(SETS), .WAYS(WAYS)
    ) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (lk_vpn),
        .hit      (set_hit),
        .hit_ppn  (set_ppn),
        .hit_perm (set_perm),
        .wr_en    (fill_valid && !fill_lock),
        .wr_vpn   (fill_vpn),
        .wr_ppn   (fill_ppn),
        .wr_perm  (fill_perm),
        .clr_all  (inv_all),
        .inv_en   (inv_addr_valid),
        .inv_vpn  (inv_addr_vpn)
    );

    // Output select: the pinned region first, then the cache; masked by enable.
    always_comb begin
        lk_hit  = 1'b0;
        lk_ppn  = '0;
        lk_perm = '0;
        if (enable && pin_hit) begin
            lk_hit  = 1'b1;
            lk_ppn  = pin_ppn;
            lk_perm = pin_perm;
        end else if (enable && set_hit) begin
            lk_hit  = 1'b1;
            lk_ppn  = set_ppn;
            lk_perm = set_perm;
        end
    end

    // R9: no hit is reported while translation is disabled
    a_r9_masked_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !lk_hit);

    // R7: a clear-all leaves the pinned valid bits untouched
    a_r7_pins_survive: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !inv_addr_valid && !(fill_valid && fill_lock)) |=> $stable(pin_valid));

    // R8: after an address invalidate with no fill, that VPN misses
    a_r8_addr_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_addr_valid && !fill_valid) |=> !(lk_hit && (lk_vpn == $past(inv_addr_vpn))));
endmodule

// File: tb/xlat_tlb_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, and each task checks its own results.
module xlat_tlb_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit;
    logic [19:0] lk_ppn;
    logic [3:0]  lk_perm;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_ppn = '0;
    logic [3:0]  fill_perm = '0;
    logic        fill_lock = 1'b0;
    logic [2:0]  fill_slot = '0;
    logic        inv_all = 1'b0;
    logic        inv_addr_valid = 1'b0;
    logic [19:0] inv_addr_vpn = '0;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    xlat_tlb u_xlat_tlb (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_perm(fill_perm), .fill_lock(fill_lock), .fill_slot(fill_slot),
        .inv_all(inv_all), .inv_addr_valid(inv_addr_valid), .inv_addr_vpn(inv_addr_vpn)
    );

    // Look up vpn between clock edges and compare hit, ppn and perm.
    task automatic look(input string req, input logic [19:0] vpn, input logic exp_hit,
                        input logic [19:0] exp_ppn, input logic [3:0] exp_perm);
        lk_vpn = vpn;
        #1;
        n_checks++;
        if (lk_hit !== exp_hit || (exp_hit && (lk_ppn !== exp_ppn || lk_perm !== exp_perm))) begin
            n_fail++;
            $display("FAIL %s vpn=%h: hit=%b ppn=%h perm=%h expected hit=%b ppn=%h perm=%h",
                     req, vpn, lk_hit, lk_ppn, lk_perm, exp_hit, exp_ppn, exp_perm);
        end
    endtask

    // One fill cycle; the write happens at the posedge in the middle.
    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [3:0] perm,
                        input logic lock, input logic [2:0] slot);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_perm = perm;
        fill_lock = lock; fill_slot = slot;
        @(negedge clk);
        fill_valid = 1'b0; fill_lock = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    task automatic clear_addr(input logic [19:0] vpn);
        @(negedge clk);
        inv_addr_valid = 1'b1; inv_addr_vpn = vpn;
        @(negedge clk);
        inv_addr_valid = 1'b0;
    endtask

    task automatic t_r1_reset();
        look("R1", 20'h00000, 1'b0, '0, '0);
        look("R1", 20'h00105, 1'b0, '0, '0);
    endtask

    task automatic t_r2_basic();
        fill(20'h00010, 20'h0AAAA, 4'h5, 1'b0, 3'd0);
        look("R2", 20'h00010, 1'b1, 20'h0AAAA, 4'h5);
        look("R2", 20'h00020, 1'b0, '0, '0);
    endtask

    task automatic t_r3_round_robin();
        fill(20'h00105, 20'h11105, 4'h1, 1'b0, 3'd0);
        fill(20'h00205, 20'h11205, 4'h2, 1'b0, 3'd0);
        look("R3", 20'h00105, 1'b1, 20'h11105, 4'h1);
        look("R3", 20'h00205, 1'b1, 20'h11205, 4'h2);
        fill(20'h00305, 20'h11305, 4'h3, 1'b0, 3'd0);
        look("R3", 20'h00105, 1'b0, '0, '0);
        look("R3", 20'h00205, 1'b1, 20'h11205, 4'h2);
        look("R3", 20'h00305, 1'b1, 20'h11305, 4'h3);
        look("R3", 20'h00010, 1'b1, 20'h0AAAA, 4'h5);
    endtask

    task automatic t_r4_refill();
        // pointer of set 5 is at way 1; refill of the VPN in way 1 moves it to way 0
        fill(20'h00205, 20'h22205, 4'h6, 1'b0, 3'd0);
        look("R4", 20'h00205, 1'b1, 20'h22205, 4'h6);
        fill(20'h00405, 20'h11405, 4'h4, 1'b0, 3'd0);
        look("R4", 20'h00305, 1'b0, '0, '0);
        look("R4", 20'h00205, 1'b1, 20'h22205, 4'h6);
        look("R4", 20'h00405, 1'b1, 20'h11405, 4'h4);
    endtask

    task automatic t_r5_r11_pinned();
        fill(20'h00707, 20'h01111, 4'h7, 1'b1, 3'd3);
        look("R5", 20'h00707, 1'b1, 20'h01111, 4'h7);
        fill(20'h00807, 20'h00807, 4'h1, 1'b0, 3'd0);
        fill(20'h00907, 20'h00907, 4'h1, 1'b0, 3'd0);
        fill(20'h00A07, 20'h00A07, 4'h1, 1'b0, 3'd0);
        look("R11", 20'h00707, 1'b1, 20'h01111, 4'h7);
        look("R11", 20'h00807, 1'b0, '0, '0);
        fill(20'h00B07, 20'h0BBBB, 4'h8, 1'b1, 3'd3);
        look("R5", 20'h00707, 1'b0, '0, '0);
        look("R5", 20'h00B07, 1'b1, 20'h0BBBB, 4'h8);
    endtask

    task automatic t_r6_priority();
        fill(20'h00C0C, 20'h02222, 4'h2, 1'b0, 3'd0);
        look("R6", 20'h00C0C, 1'b1, 20'h02222, 4'h2);
        fill(20'h00C0C, 20'h03333, 4'h3, 1'b1, 3'd0);
        look("R6", 20'h00C0C, 1'b1, 20'h03333, 4'h3);
    endtask

    task automatic t_r7_clear_all();
        clear_all();
        look("R7", 20'h00205, 1'b0, '0, '0);
        look("R7", 20'h00010, 1'b0, '0, '0);
        look("R7", 20'h00A07, 1'b0, '0, '0);
        look("R7", 20'h00B07, 1'b1, 20'h0BBBB, 4'h8);
        look("R7", 20'h00C0C, 1'b1, 20'h03333, 4'h3);
    endtask

    task automatic t_r8_clear_addr();
        fill(20'h0000E, 20'h04444, 4'h4, 1'b0, 3'd0);
        fill(20'h0001E, 20'h0401E, 4'h4, 1'b0, 3'd0);
        fill(20'h0000E, 20'h05555, 4'h5, 1'b1, 3'd5);
        look("R8", 20'h0000E, 1'b1, 20'h05555, 4'h5);
        clear_addr(20'h0000E);
        look("R8", 20'h0000E, 1'b0, '0, '0);
        look("R8", 20'h0001E, 1'b1, 20'h0401E, 4'h4);
        look("R8", 20'h00B07, 1'b1, 20'h0BBBB, 4'h8);
    endtask

    task automatic t_r9_enable();
        @(negedge clk);
        enable = 1'b0;
        look("R9", 20'h00B07, 1'b0, '0, '0);
        look("R9", 20'h0001E, 1'b0, '0, '0);
        @(negedge clk);
        @(negedge clk);
        enable = 1'b1;
        look("R9", 20'h00B07, 1'b1, 20'h0BBBB, 4'h8);
        look("R9", 20'h0001E, 1'b1, 20'h0401E, 4'h4);
    endtask

    task automatic t_r10_same_cycle();
        @(negedge clk);
        inv_all = 1'b1;
        fill_valid = 1'b1; fill_vpn = 20'h0002F; fill_ppn = 20'h0602F;
        fill_perm = 4'h9; fill_lock = 1'b0;
        @(negedge clk);
        inv_all = 1'b0; fill_valid = 1'b0;
        look("R10", 20'h0002F, 1'b1, 20'h0602F, 4'h9);
        look("R10", 20'h0001E, 1'b0, '0, '0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_r1_reset();
        t_r2_basic();
        t_r3_round_robin();
        t_r4_refill();
        t_r5_r11_pinned();
        t_r6_priority();
        t_r7_clear_all();
        t_r8_clear_addr();
        t_r9_enable();
        t_r10_same_cycle();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule